// File: doc/BRIEF.md
# Prescaled Interval Timer

This block is a programmable up-counting timer for interval and delay generation. Software sets a terminal count in the period register, can set a divide ratio in the prescale register, and picks one of two run codes in the control register. In the single-run code the timer counts once, raises its event, returns to zero and switches itself off. In the repeating code it returns to zero and keeps going, which gives a periodic interrupt. Each terminal count produces a one-cycle interrupt pulse and a matching one-cycle DMA request pulse. It also toggles a timer output pin, whose level software can read as a status bit.

The count can advance on every internal clock cycle or on rising edges of an external clock. The external clock passes through a multi-flop synchronizer and an edge detector, so the counter advances at most once per internal cycle. A soft-reset bit in a separate global register holds the status at zero and releases the output driver while it is low. Whether the prescaler is built at all is chosen by a parameter.

Top module: `tmr_top`

## Requirements
- R1: After hardware reset every register reads 0: control (bits 1:0 run code, bit 2 external source, bit 3 status), period (address 1), prescale (address 2), count (address 3) and global (address 4, bit 0 soft-reset release). The interrupt and DMA outputs are 0 and the output enable is 0.
- R2: With run code 10 (repeating) and prescale 0 on the internal clock, the interrupt pulses for one cycle every period+1 cycles. The first pulse comes period+1 cycles after the cycle in which the control write takes effect, and the count reads 0 in the pulse cycle.
- R3: With run code 01 (single run), exactly one interrupt pulse follows. The run code then reads 00 and the count stays at 0.
- R4: Run codes 00 and 11 leave the count unchanged.
- R5: While the period and the count are both 0, an enabled timer keeps the count at 0 and raises no interrupt.
- R6: With prescale value S and period P in the repeating code, the count advances one cycle after each prescaler terminal count, and interrupts come every (P+1)*(S+1) cycles.
- R7: With control bit 2 set, the count advances exactly once per rising edge of the external clock input and holds while that input is steady.
- R8: The DMA event pulse appears in exactly the same cycles as the interrupt pulse.
- R9: Each terminal count toggles the timer output while the soft-reset bit is 1, and control bit 3 reads the output level.
- R10: While global bit 0 is 0, the output enable is 0 and the status bit reads 0. Setting the bit to 1 drives the output again from level 0.
- R11: Writing the count register loads the count, restarts the prescaler from 0, and overrides counting in that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Internal clock |
| rst_n | input | 1 | Active-low hardware reset, asynchronous |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Write register address |
| wr_data | input | DATA_W | Write data |
| rd_addr | input | 3 | Read register address |
| rd_data | output | DATA_W | Read data, combinational from rd_addr |
| ext_clk_i | input | 1 | External count clock, asynchronous |
| irq_o | output | 1 | Terminal-count interrupt pulse |
| dma_evt_o | output | 1 | Terminal-count DMA request pulse |
| tout_o | output | 1 | Timer output level |
| tout_oe_o | output | 1 | Timer output drive enable (0 = high impedance) |

## Verification
A register write takes effect at the clock edge that follows its strobe. On the internal clock, the terminal count is reached P cycles after that edge, and the interrupt, the DMA request and the wrap of the count to 0 all appear one edge later. This gives pulses at P+1 edges and multiples of it, or (P+1)*(S+1) with the prescaler. The bench records the edge count at which each run code takes effect and pushes the expected pulse edge numbers into a queue. A monitor that samples on the falling edge pops them and compares them, and any pulse that no prescribed entry explains is reported. External-clock counts are read only after enough idle cycles for the synchronizer latency of about three cycles to pass.

// File: rtl/tmr_pkg.sv
package tmr_pkg;

   typedef enum logic [1:0] {
      RUN_OFF  = 2'b00,
      RUN_ONCE = 2'b01,
      RUN_LOOP = 2'b10,
      RUN_RSVD = 2'b11
   } run_mode_e;

   localparam logic [2:0] ADDR_CTRL     = 3'd0;
   localparam logic [2:0] ADDR_PERIOD   = 3'd1;
   localparam logic [2:0] ADDR_PRESCALE = 3'd2;
   localparam logic [2:0] ADDR_COUNT    = 3'd3;
   localparam logic [2:0] ADDR_GLOBAL   = 3'd4;

   localparam int CTRL_SRC_BIT  = 2;
   localparam int CTRL_STAT_BIT = 3;
   localparam int GLB_REL_BIT   = 0;

endpackage

// File: rtl/tmr_edge_sync.sv
module tmr_edge_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic async_i,
   output logic rise_o
);

   localparam int CHAIN_W = STAGES + 1;

   if (STAGES < 2) begin : g_bad_stages
      $error("tmr_edge_sync: STAGES must be at least 2");
   end

   logic [CHAIN_W-1:0] chain_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain_q <= '0;
      else        chain_q <= {chain_q[CHAIN_W-2:0], async_i};
   end

   // last synchronized sample high, previous sample low
   assign rise_o = chain_q[STAGES-1] & ~chain_q[STAGES];

endmodule

// File: rtl/tmr_regs.sv
module tmr_regs
   import tmr_pkg::*;
#(
   parameter int DATA_W  = 32,
   parameter int CNT_W   = 16,
   parameter int PRE_W   = 8,
   parameter bit HAS_PRE = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [2:0]        wr_addr,
   input  logic [DATA_W-1:0] wr_data,
   input  logic [2:0]        rd_addr,
   output logic [DATA_W-1:0] rd_data,
   input  logic [CNT_W-1:0]  cnt_i,
   input  logic              status_i,
   input  logic              done_i,
   output run_mode_e         mode_o,
   output logic              src_ext_o,
   output logic [CNT_W-1:0]  period_o,
   output logic [PRE_W-1:0]  prescale_o,
   output logic              ld_o,
   output logic [CNT_W-1:0]  ld_val_o,
   output logic              rel_o
);

   run_mode_e          mode_q;
   logic               src_q;
   logic [CNT_W-1:0]   period_q;
   logic [PRE_W-1:0]   pre_val;
   logic               rel_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mode_q   <= RUN_OFF;
         src_q    <= 1'b0;
         period_q <= '0;
         rel_q    <= 1'b0;
      end else begin
         if (done_i) mode_q <= RUN_OFF;
         if (wr_en) begin
            case (wr_addr)
               ADDR_CTRL: begin
                  mode_q <= run_mode_e'(wr_data[1:0]);
                  src_q  <= wr_data[CTRL_SRC_BIT];
               end
               ADDR_PERIOD: period_q <= wr_data[CNT_W-1:0];
               ADDR_GLOBAL: rel_q    <= wr_data[GLB_REL_BIT];
               default: ;
            endcase
         end
      end
   end

   if (HAS_PRE) begin : g_pre_reg
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)
            pre_val <= '0;
         else if (wr_en && wr_addr == ADDR_PRESCALE)
            pre_val <= wr_data[PRE_W-1:0];
      end
   end else begin : g_no_pre_reg
      assign pre_val = '0;
   end

   always_comb begin
      rd_data = '0;
      case (rd_addr)
         ADDR_CTRL: begin
            rd_data[1:0]          = mode_q;
            rd_data[CTRL_SRC_BIT]  = src_q;
            rd_data[CTRL_STAT_BIT] = status_i;
         end
         ADDR_PERIOD:   rd_data[CNT_W-1:0] = period_q;
         ADDR_PRESCALE: rd_data[PRE_W-1:0] = pre_val;
         ADDR_COUNT:    rd_data[CNT_W-1:0] = cnt_i;
         ADDR_GLOBAL:   rd_data[GLB_REL_BIT] = rel_q;
         default: ;
      endcase
   end

   assign mode_o     = mode_q;
   assign src_ext_o  = src_q;
   assign period_o   = period_q;
   assign prescale_o = pre_val;
   assign ld_o       = wr_en && (wr_addr == ADDR_COUNT);
   assign ld_val_o   = wr_data[CNT_W-1:0];
   assign rel_o      = rel_q;

endmodule

// File: rtl/tmr_count_core.sv
module tmr_count_core
   import tmr_pkg::*;
#(
   parameter int CNT_W   = 16,
   parameter int PRE_W   = 8,
   parameter bit HAS_PRE = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  run_mode_e        mode_i,
   input  logic             src_ext_i,
   input  logic             ext_rise_i,
   input  logic [CNT_W-1:0] period_i,
   input  logic [PRE_W-1:0] prescale_i,
   input  logic             ld_i,
   input  logic [CNT_W-1:0] ld_val_i,
   output logic [CNT_W-1:0] cnt_o,
   output logic             match_o,
   output logic             done_o
);

   logic [CNT_W-1:0] cnt_q;
   logic             running;
   logic             tick;
   logic             frozen;
   logic             adv;
   logic             step;
   logic             match;

   assign running = (mode_i == RUN_ONCE) || (mode_i == RUN_LOOP);
   assign tick    = src_ext_i ? ext_rise_i : 1'b1;
   // a zero period with a zero count never starts
   assign frozen  = (period_i == '0) && (cnt_q == '0);
   assign adv     = running && tick && !frozen && !ld_i;

   if (HAS_PRE) begin : g_prescaler
      logic [PRE_W-1:0] pre_q;
      logic             pre_term;

      assign pre_term = (pre_q == prescale_i);

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)       pre_q <= '0;
         else if (ld_i)    pre_q <= '0;
         else if (adv)     pre_q <= pre_term ? '0 : pre_q + 1'b1;
      end

      assign step = adv && pre_term;
   end else begin : g_direct
      logic unused_prescale;
      assign unused_prescale = ^prescale_i;
      assign step = adv;
   end

   assign match = step && (cnt_q == period_i);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      cnt_q <= '0;
      else if (ld_i)   cnt_q <= ld_val_i;
      else if (match)  cnt_q <= '0;
      else if (step)   cnt_q <= cnt_q + 1'b1;
   end

   assign cnt_o   = cnt_q;
   assign match_o = match;
   assign done_o  = match && (mode_i == RUN_ONCE);

endmodule

// File: rtl/tmr_out.sv
module tmr_out (
   input  logic clk,
   input  logic rst_n,
   input  logic rel_i,
   input  logic match_i,
   output logic irq_o,
   output logic dma_o,
   output logic tout_o,
   output logic tout_oe_o,
   output logic status_o
);

   logic irq_q;
   logic dma_q;
   logic lvl_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         irq_q <= 1'b0;
         dma_q <= 1'b0;
      end else begin
         irq_q <= match_i;
         dma_q <= match_i;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       lvl_q <= 1'b0;
      else if (!rel_i)  lvl_q <= 1'b0;
      else if (match_i) lvl_q <= ~lvl_q;
   end

   assign irq_o     = irq_q;
   assign dma_o     = dma_q;
   assign tout_o    = lvl_q & rel_i;
   assign tout_oe_o = rel_i;
   assign status_o  = lvl_q & rel_i;

endmodule

// File: rtl/tmr_top.sv
module tmr_top
   import tmr_pkg::*;
#(
   parameter int DATA_W        = 32,
   parameter int CNT_W         = 16,
   parameter int PRE_W         = 8,
   parameter bit HAS_PRESCALER = 1'b1,
   parameter int SYNC_STAGES   = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [2:0]        wr_addr,
   input  logic [DATA_W-1:0] wr_data,
   input  logic [2:0]        rd_addr,
   output logic [DATA_W-1:0] rd_data,
   input  logic              ext_clk_i,
   output logic              irq_o,
   output logic              dma_evt_o,
   output logic              tout_o,
   output logic              tout_oe_o
);

   if (CNT_W < 2 || CNT_W > DATA_W) begin : g_bad_cnt_w
      $error("tmr_top: CNT_W must lie in 2..DATA_W");
   end
   if (PRE_W < 1 || PRE_W > DATA_W) begin : g_bad_pre_w
      $error("tmr_top: PRE_W must lie in 1..DATA_W");
   end
   if (DATA_W < 8) begin : g_bad_data_w
      $error("tmr_top: DATA_W must be at least 8");
   end

   run_mode_e        mode_w;
   logic             src_w;
   logic [CNT_W-1:0] period_w;
   logic [PRE_W-1:0] prescale_w;
   logic             ld_w;
   logic [CNT_W-1:0] ld_val_w;
   logic             rel_w;
   logic [CNT_W-1:0] cnt_w;
   logic             match_w;
   logic             done_w;
   logic             status_w;
   logic             ext_rise_w;

   tmr_regs #(
      .DATA_W (DATA_W),
      .CNT_W  (CNT_W),
      .PRE_W  (PRE_W),
      .HAS_PRE(HAS_PRESCALER)
   ) u_regs (
      .clk       (clk),
      .rst_n     (rst_n),
      .wr_en     (wr_en),
      .wr_addr   (wr_addr),
      .wr_data   (wr_data),
      .rd_addr   (rd_addr),
      .rd_data   (rd_data),
      .cnt_i     (cnt_w),
      .status_i  (status_w),
      .done_i    (done_w),
      .mode_o    (mode_w),
      .src_ext_o (src_w),
      .period_o  (period_w),
      .prescale_o(prescale_w),
      .ld_o      (ld_w),
      .ld_val_o  (ld_val_w),
      .rel_o     (rel_w)
   );

   tmr_edge_sync #(
      .STAGES(SYNC_STAGES)
   ) u_sync (
      .clk    (clk),
      .rst_n  (rst_n),
      .async_i(ext_clk_i),
      .rise_o (ext_rise_w)
   );

   tmr_count_core #(
      .CNT_W  (CNT_W),
      .PRE_W  (PRE_W),
      .HAS_PRE(HAS_PRESCALER)
   ) u_core (
      .clk       (clk),
      .rst_n     (rst_n),
      .mode_i    (mode_w),
      .src_ext_i (src_w),
      .ext_rise_i(ext_rise_w),
      .period_i  (period_w),
      .prescale_i(prescale_w),
      .ld_i      (ld_w),
      .ld_val_i  (ld_val_w),
      .cnt_o     (cnt_w),
      .match_o   (match_w),
      .done_o    (done_w)
   );

   tmr_out u_out (
      .clk      (clk),
      .rst_n    (rst_n),
      .rel_i    (rel_w),
      .match_i  (match_w),
      .irq_o    (irq_o),
      .dma_o    (dma_evt_o),
      .tout_o   (tout_o),
      .tout_oe_o(tout_oe_o),
      .status_o (status_w)
   );

endmodule

// File: rtl/tmr_chk.sv
module tmr_chk #(
   parameter int CNT_W = 16
) (
   input logic             clk,
   input logic             rst_n,
   input logic             irq_o,
   input logic             dma_evt_o,
   input logic             tout_o,
   input logic             tout_oe_o,
   input logic [CNT_W-1:0] cnt,
   input logic [CNT_W-1:0] period,
   input logic [1:0]       mode,
   input logic             ld,
   input logic             rel,
   input logic             status
);

   p_irq_single_r2: assert property (@(posedge clk) disable iff (!rst_n)
      irq_o |=> !irq_o);

   p_wrap_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
      irq_o |-> (cnt == '0));

   p_oneshot_off_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (irq_o && $past(mode) == 2'b01) |-> (mode == 2'b00));

   p_idle_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
      ((mode == 2'b00 || mode == 2'b11) && !ld) |=> $stable(cnt));

   p_zero_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (period == '0 && cnt == '0 && !ld) |=> (cnt == '0));

   p_dma_with_irq_r8: assert property (@(posedge clk) disable iff (!rst_n)
      dma_evt_o == irq_o);

   p_tout_toggle_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (irq_o && $past(rel) && rel) |-> (tout_o != $past(tout_o)));

   p_release_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
      !rel |-> (!tout_oe_o && !status));

endmodule

bind tmr_top tmr_chk #(.CNT_W(CNT_W)) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .irq_o    (irq_o),
   .dma_evt_o(dma_evt_o),
   .tout_o   (tout_o),
   .tout_oe_o(tout_oe_o),
   .cnt      (cnt_w),
   .period   (period_w),
   .mode     (mode_w),
   .ld       (ld_w),
   .rel      (rel_w),
   .status   (status_w)
);

// File: tb/tb_tmr_top.sv
module tb_tmr_top;

   localparam int DW = 32;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          wr_en = 1'b0;
   logic [2:0]    wr_addr = '0;
   logic [DW-1:0] wr_data = '0;
   logic [2:0]    rd_addr = '0;
   logic [DW-1:0] rd_data;
   logic          ext_clk_i = 1'b0;
   logic          irq_o;
   logic          dma_evt_o;
   logic          tout_o;
   logic          tout_oe_o;

   int n_checks = 0;
   int n_err    = 0;
   int cyc      = 0;
   int irq_seen = 0;
   int exp_q[$];
   string tag_q[$];
   bit done_flag = 1'b0;

   tmr_top dut (
      .clk      (clk),
      .rst_n    (rst_n),
      .wr_en    (wr_en),
      .wr_addr  (wr_addr),
      .wr_data  (wr_data),
      .rd_addr  (rd_addr),
      .rd_data  (rd_data),
      .ext_clk_i(ext_clk_i),
      .irq_o    (irq_o),
      .dma_evt_o(dma_evt_o),
      .tout_o   (tout_o),
      .tout_oe_o(tout_oe_o)
   );

   always #4 clk = ~clk;

   always @(posedge clk) cyc <= cyc + 1;

   task automatic chk(input string tag, input logic [DW-1:0] act, input logic [DW-1:0] exp);
      n_checks++;
      if (act !== exp) begin
         n_err++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   task automatic wr(input logic [2:0] a, input logic [DW-1:0] d);
      @(negedge clk);
      wr_en = 1'b1; wr_addr = a; wr_data = d;
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   task automatic rd(input logic [2:0] a, output logic [DW-1:0] v);
      rd_addr = a;
      #1;
      v = rd_data;
   endtask

   task automatic expect_irq(input int at, input string tag);
      exp_q.push_back(at);
      tag_q.push_back(tag);
   endtask

   task automatic wait_until(input int c);
      while (cyc < c) @(negedge clk);
   endtask

   // monitor: pops predicted pulse edges as pulses appear
   always @(negedge clk) begin
      if (rst_n && irq_o) begin
         irq_seen++;
         chk("R8 dma with irq", dma_evt_o, 1'b1);
         if (exp_q.size() == 0) begin
            n_checks++;
            n_err++;
            $display("FAIL R2 unexpected irq actual=%0d expected=none", cyc);
         end else begin
            int e;
            string t;
            e = exp_q.pop_front();
            t = tag_q.pop_front();
            chk(t, cyc, e);
         end
      end else if (rst_n && dma_evt_o) begin
         chk("R8 dma without irq", dma_evt_o, 1'b0);
      end
   end

   task automatic summary();
      $display("  Simulation finished: %0d checks, %0d errors", n_checks, n_err);
      $finish;
   endtask

   initial begin
      repeat (40000) @(posedge clk);
      if (!done_flag) begin
         n_checks++;
         n_err++;
         $display("FAIL watchdog actual=%0d expected=done", cyc);
         summary();
      end
   end

   initial begin
      logic [DW-1:0] v;
      int c0;

      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R1 reset state
      rd(3'd0, v); chk("R1 ctrl", v, 0);
      rd(3'd1, v); chk("R1 period", v, 0);
      rd(3'd2, v); chk("R1 prescale", v, 0);
      rd(3'd3, v); chk("R1 count", v, 0);
      rd(3'd4, v); chk("R1 global", v, 0);
      chk("R1 irq", irq_o, 0);
      chk("R1 dma", dma_evt_o, 0);
      chk("R1 oe", tout_oe_o, 0);

      wr(3'd4, 1);
      chk("R10 oe released", tout_oe_o, 1);

      // R11 load, R4 idle codes
      wr(3'd1, 5);
      wr(3'd3, 3);
      rd(3'd3, v); chk("R11 load", v, 3);
      wr(3'd0, 3);
      repeat (6) @(negedge clk);
      rd(3'd3, v); chk("R4 code 11 holds", v, 3);
      wr(3'd0, 0);
      repeat (4) @(negedge clk);
      rd(3'd3, v); chk("R4 code 00 holds", v, 3);

      // R2 repeating, period 4
      wr(3'd3, 0);
      wr(3'd1, 4);
      wr(3'd0, 2);
      c0 = cyc;
      for (int k = 1; k <= 3; k++) expect_irq(c0 + 5 * k, "R2 repeat pulse");
      wait_until(c0 + 5);
      rd(3'd3, v); chk("R2 wrap to zero", v, 0);
      wait_until(c0 + 16);
      wr(3'd0, 0);
      chk("R2 queue drained", exp_q.size(), 0);
      rd(3'd0, v); chk("R9 status odd", v[3], 1'b1);
      chk("R9 tout level", tout_o, 1'b1);

      // R6 prescaler 1, period 2
      wr(3'd2, 1);
      wr(3'd3, 0);
      wr(3'd1, 2);
      wr(3'd0, 2);
      c0 = cyc;
      expect_irq(c0 + 6, "R6 prescaled pulse");
      expect_irq(c0 + 12, "R6 prescaled pulse");
      wait_until(c0 + 8);
      rd(3'd3, v); chk("R6 count mid", v, 1);
      wait_until(c0 + 13);
      wr(3'd0, 0);
      chk("R6 queue drained", exp_q.size(), 0);

      // R3 single run, period 3
      wr(3'd2, 0);
      wr(3'd3, 0);
      wr(3'd1, 3);
      wr(3'd0, 1);
      c0 = cyc;
      expect_irq(c0 + 4, "R3 single pulse");
      wait_until(c0 + 12);
      rd(3'd0, v); chk("R3 self off", v[1:0], 2'b00);
      rd(3'd3, v); chk("R3 count zero", v, 0);
      chk("R3 queue drained", exp_q.size(), 0);
      rd(3'd0, v); chk("R9 status even", v[3], 1'b0);

      // R5 zero period and zero count
      wr(3'd1, 0);
      wr(3'd3, 0);
      wr(3'd0, 2);
      repeat (10) @(negedge clk);
      rd(3'd3, v); chk("R5 frozen", v, 0);
      wr(3'd0, 0);

      // R7 external source
      wr(3'd1, 100);
      wr(3'd3, 0);
      wr(3'd0, 6);
      repeat (6) @(negedge clk);
      rd(3'd3, v); chk("R7 idle ext holds", v, 0);
      for (int i = 0; i < 5; i++) begin
         ext_clk_i = 1'b1;
         repeat (3) @(negedge clk);
         ext_clk_i = 1'b0;
         repeat (3) @(negedge clk);
      end
      repeat (5) @(negedge clk);
      rd(3'd3, v); chk("R7 ext edges", v, 5);
      wr(3'd0, 0);

      // R10 soft reset after an odd pulse count
      wr(3'd1, 1);
      wr(3'd3, 0);
      wr(3'd0, 1);
      c0 = cyc;
      expect_irq(c0 + 2, "R3 single pulse short");
      wait_until(c0 + 5);
      rd(3'd0, v); chk("R9 status set", v[3], 1'b1);
      wr(3'd4, 0);
      chk("R10 oe off", tout_oe_o, 1'b0);
      rd(3'd0, v); chk("R10 status cleared", v[3], 1'b0);
      wr(3'd4, 1);
      chk("R10 oe back", tout_oe_o, 1'b1);
      chk("R10 restart low", tout_o, 1'b0);
      chk("R8 pulses seen", irq_seen, 7);

      done_flag = 1'b1;
      summary();
   end

endmodule